// File: doc/BRIEF.md
# Datapath Shifter with Carry-Out

This block is the operand-2 shifter of a 32-bit RISC datapath. It shifts or rotates an operand by a 5-bit amount, using one of four shift kinds. Alongside the result it produces the shifter carry, which the ALU may later load into its C flag. A shift amount of zero does not mean "no shift" for every kind. For a left shift it passes the operand through. For the two right shifts it means a shift by 32. For a rotate it means a one-bit rotate through the incoming carry flag.

The shift logic is purely combinational. A parameter `OUT_REG` decides how the outputs leave the block:
- With `OUT_REG` = 1 (the default), the outputs go through one register stage for timing, so each result appears one clock after its inputs.
- With `OUT_REG` = 0, the outputs come straight from the combinational logic.

The register stage has an asynchronous active-low reset that is released in step with the clock.

Top module: `bshift_unit`

## Requirements
- R1: Shift kind `2'b00` is a logical left shift. With an amount of 0, the result equals the operand and the carry-out equals `carry_in`.
- R2: Logical left shift by n (1..31) gives the operand shifted left with zeros entering at the bottom. The carry-out is operand bit 32−n.
- R3: Shift kind `2'b01` is a logical right shift. An amount of 0 means a shift by 32: the result is zero and the carry-out is operand bit 31.
- R4: Logical right shift by n (1..31) gives the operand shifted right with zeros entering at the top. The carry-out is operand bit n−1.
- R5: Shift kind `2'b10` is an arithmetic right shift. An amount of 0 gives every result bit equal to operand bit 31, and the carry-out also equals bit 31.
- R6: Arithmetic right shift by n (1..31) fills the top n result bits with operand bit 31. The carry-out is operand bit n−1.
- R7: Shift kind `2'b11` is a rotate right. An amount of 0 means rotate right by one through the carry flag: `carry_in` enters result bit 31, operand bits 31..1 move down one place, and the carry-out is operand bit 0.
- R8: Rotate right by n (1..31) moves the n bits shifted out at the bottom back in at the top. The carry-out is operand bit n−1.
- R9: With `OUT_REG` = 1, the result and carry for the inputs present at a rising clock edge appear after that edge and hold until the next edge. While `rst_n` is low, and for two clock edges after it rises, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 32 | Value to be shifted |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| shift_amt | input | 5 | Shift amount; 0 has the per-kind meaning given in R1, R3, R5 and R7 |
| carry_in | input | 1 | Current C flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Two carry paths can meet in the same cycle. In the rotate-through-carry case (R7), the incoming carry flag becomes data in result bit 31 while operand bit 0 becomes the new carry-out. A design that mixes up the two paths can still look right whenever both values happen to be equal. The bench therefore drives this case with `carry_in` different from operand bit 0, in both polarities, and judges result bit 31 and `carry_out` separately against a reference model. A left shift by zero (R1) is also checked with `carry_in` opposite to every operand bit that a wrong index could select.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    shift_kind_e kind;
    logic        amt_zero;
  } shift_plan_t;

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  output shift_plan_t      plan_o,
  output logic [AMT_W-1:0] rot_amt_o
);

  shift_kind_e kind;

  always_comb begin
    kind            = shift_kind_e'(kind_i);
    plan_o.kind     = kind;
    plan_o.amt_zero = (amt_i == '0);
    // a left shift by n is a right rotate by (width - n), masked afterwards
    if (kind == SK_LSL) rot_amt_o = -amt_i;
    else                rot_amt_o = amt_i;
  end

endmodule

// File: rtl/bshift_rotr.sv
module bshift_rotr #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 5
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout
);

  // logarithmic rotator: stage s rotates by 2**s when amt[s] is set
  always_comb begin
    logic [WIDTH-1:0] cur;
    cur = din;
    for (int s = 0; s < AMT_W; s++) begin
      if (amt[s]) cur = (cur >> (1 << s)) | (cur << (WIDTH - (1 << s)));
    end
    dout = cur;
  end

endmodule

// File: rtl/bshift_fixup.sv
module bshift_fixup
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 5
) (
  input  shift_plan_t      plan,
  input  logic [WIDTH-1:0] opd,
  input  logic [WIDTH-1:0] rot,
  input  logic [AMT_W-1:0] amt,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             c_out
);

  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] top_mask;
  logic             sign;

  assign sign = opd[WIDTH-1];

  // thermometer masks: low n bits, and top n bits
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      low_mask[i] = (i < int'(amt));
      top_mask[i] = (i + int'(amt) >= WIDTH);
    end
  end

  always_comb begin
    res   = rot;
    c_out = c_in;
    if (plan.amt_zero) begin
      unique case (plan.kind)
        SK_LSL: begin res = opd;                       c_out = c_in;     end
        SK_LSR: begin res = '0;                        c_out = sign;     end
        SK_ASR: begin res = {WIDTH{sign}};             c_out = sign;     end
        SK_ROR: begin res = {c_in, opd[WIDTH-1:1]};    c_out = opd[0];   end
        default: begin res = opd;                      c_out = c_in;     end
      endcase
    end else begin
      unique case (plan.kind)
        SK_LSL: begin res = rot & ~low_mask;           c_out = rot[0];   end
        SK_LSR: begin res = rot & ~top_mask;           c_out = rot[WIDTH-1]; end
        SK_ASR: begin
          res   = (rot & ~top_mask) | (top_mask & {WIDTH{sign}});
          c_out = rot[WIDTH-1];
        end
        SK_ROR: begin res = rot;                       c_out = rot[WIDTH-1]; end
        default: begin res = rot;                      c_out = c_in;     end
      endcase
    end
  end

endmodule

// File: rtl/bshift_out_stage.sv
module bshift_out_stage #(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_c,
  output logic [WIDTH-1:0] q_res,
  output logic             q_c
);

  generate
    if (OUT_REG) begin : g_reg
      logic [1:0]       rst_sync;
      logic             run;
      logic [WIDTH-1:0] res_q, res_d;
      logic             c_q, c_d;

      // reset asserts at once, releases after two edges
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync <= 2'b00;
        else        rst_sync <= {rst_sync[0], 1'b1};
      end
      assign run = rst_sync[1];

      always_comb begin
        res_d = run ? d_res : '0;
        c_d   = run ? d_c   : 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          c_q   <= 1'b0;
        end else begin
          res_q <= res_d;
          c_q   <= c_d;
        end
      end

      assign q_res = res_q;
      assign q_c   = c_q;

      p_stage_follow_r9: assert property (@(posedge clk) disable iff (!run)
        $past(run) |=> (q_res == $past(d_res)) && (q_c == $past(d_c)));
    end else begin : g_comb
      assign q_res = d_res;
      assign q_c   = d_c;
    end
  endgenerate

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AMT_W  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       shift_kind,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  shift_plan_t      plan;
  logic [AMT_W-1:0] rot_amt;
  logic [WIDTH-1:0] rot_val;
  logic [WIDTH-1:0] core_res;
  logic             core_c;

  bshift_decode #(.AMT_W(AMT_W)) i_decode (
    .kind_i   (shift_kind),
    .amt_i    (shift_amt),
    .plan_o   (plan),
    .rot_amt_o(rot_amt)
  );

  bshift_rotr #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_rotr (
    .din (operand),
    .amt (rot_amt),
    .dout(rot_val)
  );

  bshift_fixup #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_fixup (
    .plan (plan),
    .opd  (operand),
    .rot  (rot_val),
    .amt  (shift_amt),
    .c_in (carry_in),
    .res  (core_res),
    .c_out(core_c)
  );

  bshift_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) i_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d_res(core_res),
    .d_c  (core_c),
    .q_res(result),
    .q_c  (carry_out)
  );

  // carry and zero-amount behaviour, checked against the ports
  p_lsl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind == 2'b00 && shift_amt == '0) |-> (core_res == operand && core_c == carry_in));

  p_lsl_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind == 2'b00 && shift_amt != '0) |-> (core_c == operand[WIDTH - int'(shift_amt)]));

  p_lsr_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind == 2'b01 && shift_amt == '0) |-> (core_res == '0 && core_c == operand[WIDTH-1]));

  p_right_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind != 2'b00 && shift_amt != '0) |-> (core_c == operand[int'(shift_amt) - 1]));

  p_asr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind == 2'b10 && shift_amt == '0) |-> ($countones(core_res) == (operand[WIDTH-1] ? WIDTH : 0)));

  p_rrx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_kind == 2'b11 && shift_amt == '0) |-> (core_res[WIDTH-1] == carry_in && core_c == operand[0]));

endmodule

// File: tb/test_bshift_unit.sv
`timescale 1ns/1ps
module test_bshift_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] operand;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bshift_unit i_bshift_unit (
    .clk(clk), .rst_n(rst_n), .operand(operand), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(logic [31:0] x, logic [1:0] k, logic [4:0] n, logic c);
    int m;
    m = int'(n);
    case (k)
      2'b00: return (m == 0) ? {c, x} : {x[32-m], x << m};
      2'b01: return (m == 0) ? {x[31], 32'h0} : {x[m-1], x >> m};
      2'b10: return (m == 0) ? {x[31], {32{x[31]}}} : {x[m-1], 32'($signed(x) >>> m)};
      default: return (m == 0) ? {x[0], c, x[31:1]} : {x[m-1], (x >> m) | (x << (32 - m))};
    endcase
  endfunction

  function automatic string tag(logic [1:0] k, logic [4:0] n);
    case (k)
      2'b00: return (n == 0) ? "R1" : "R2";
      2'b01: return (n == 0) ? "R3" : "R4";
      2'b10: return (n == 0) ? "R5" : "R6";
      default: return (n == 0) ? "R7" : "R8";
    endcase
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got c=%0b res=%08h, expected c=%0b res=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // drive on negedge, register captures at posedge, sample on following negedge
  task automatic run_one(logic [31:0] x, logic [1:0] k, logic [4:0] n, logic c);
    logic [32:0] prev;
    @(negedge clk);
    prev = {carry_out, result};
    operand = x; shift_kind = k; shift_amt = n; carry_in = c;
    #1;
    check("R9 hold", {carry_out, result}, prev);
    @(negedge clk);
    check(tag(k, n), {carry_out, result}, model(x, k, n, c));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    operand = 32'hFFFF_FFFF; shift_kind = 2'b00; shift_amt = 5'd0; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", {carry_out, result}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 release", {carry_out, result}, 33'h0);
    repeat (2) @(negedge clk);
    check("R9 run", {carry_out, result}, {1'b1, 32'hFFFF_FFFF});
  endtask

  task automatic t_corners;
    logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 2; c++) begin
          run_one(pats[p], 2'(k), 5'd0,  1'(c));
          run_one(pats[p], 2'(k), 5'd1,  1'(c));
          run_one(pats[p], 2'(k), 5'd31, 1'(c));
        end
  endtask

  task automatic t_rrx_conflict;
    // R7: carry_in differs from operand bit 0
    run_one(32'h0000_0000, 2'b11, 5'd0, 1'b1);
    run_one(32'hFFFF_FFFF, 2'b11, 5'd0, 1'b0);
    // R1: carry_in opposite to all operand bits
    run_one(32'h0000_0000, 2'b00, 5'd0, 1'b1);
    run_one(32'hFFFF_FFFF, 2'b00, 5'd0, 1'b0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++)
      run_one($urandom(), 2'($urandom()), 5'($urandom()), 1'($urandom()));
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_rrx_conflict();
    t_random();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule